// File: doc/BRIEF.md
# Bypass Source Location Scoreboard

This block is a table with one entry per physical register tag. Each entry says where the value for that tag can be picked up. The value is either on the bypass of the execution lane that produces it, or already in the register file. The entry also carries a producer sequence number, so that a late writeback from an earlier owner of the tag is not mistaken for the current one.

Each of the `LANES` issue ports has two source lookups and one schedule-time destination write. Port `i` always records lane `i` as the producer. There are also `LANES` writeback-complete ports. A writeback returns an entry to the register-file state, but only if its sequence number matches the one stored.

For every source lookup the block returns an encoded bypass multiplexer select. Writes made in a cycle are forwarded to the lookups of that same cycle, so a consumer scheduled beside its producer sees the new location at once.

Top module: `bypass_loc_sb`

## Requirements
- R1: After reset every entry is in the register-file state, so every lookup returns the select value `LANES`.
- R2: A schedule write on port i for tag T makes every later lookup of T return i, until the entry is changed again.
- R3: A schedule write for tag T is visible to lookups of T in the same cycle, with no extra cycle of delay.
- R4: A writeback for tag T whose sequence number equals the stored one puts T in the register-file state. Lookups of T in that same cycle already return `LANES`.
- R5: A writeback for tag T whose sequence number differs from the stored one has no effect on the entry.
- R6: If a schedule write and a writeback name the same tag in one cycle, the schedule write wins and the entry records the scheduling lane.
- R7: If several schedule ports name the same tag in one cycle, the lowest-numbered port wins.
- R8: Each select is `$clog2(LANES+1)` bits wide. Values 0 to `LANES-1` name a lane bypass, and the value `LANES` names the register-file path.
- R9: An entry that no valid write names in a cycle keeps its lane, sequence number and state.
- R10: All `2*LANES` lookups resolve independently and in parallel, including lookups of the same tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_tag | input | 2*LANES x TAG_W | Source tags looked up this cycle; lookup 2i and 2i+1 belong to issue port i |
| src_sel | output | 2*LANES x SEL_W | Bypass select per lookup: lane index, or `LANES` for register file |
| sch_vld | input | LANES | Schedule write valid per issue port |
| sch_tag | input | LANES x TAG_W | Destination tag per issue port |
| sch_seq | input | LANES x SEQ_W | Producer sequence number per issue port |
| wb_vld | input | LANES | Writeback-complete valid per port |
| wb_tag | input | LANES x TAG_W | Tag whose value reached the register file |
| wb_seq | input | LANES x SEQ_W | Sequence number of that producer |

## Verification
On every cycle the assertions check several things:
- every select stays inside its encoding;
- a same-cycle schedule hit always yields a lane;
- port 0 wins a schedule collision;
- a matching writeback alone yields the register-file path;
- an entry no write names stays unchanged;
- reset leaves every entry in the register-file state.

Some outcomes only the bench scenarios can show. These are the actual lane chosen for each source, the rejection of stale writebacks over the following cycles, and the persistence of a location over long random write and read mixes. The bench compares those against a behavioural reference table.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
   // width of a field able to hold values 0..n-1, never below one bit
   function automatic int unsigned bsl_bits(input int unsigned n);
      int unsigned w;
      w = (n <= 1) ? 1 : $clog2(n);
      return w;
   endfunction
endpackage

// File: rtl/bsl_merge.sv
module bsl_merge #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned TAG_W  = 6,
   parameter int unsigned SEQ_W  = 4,
   parameter int unsigned LANE_W = 2
) (
   input  logic [TAG_W-1:0]             tag_i,
   input  logic                         cur_rf_i,
   input  logic [LANE_W-1:0]            cur_lane_i,
   input  logic [SEQ_W-1:0]             cur_seq_i,
   input  logic [LANES-1:0]             sch_vld_i,
   input  logic [LANES-1:0][TAG_W-1:0]  sch_tag_i,
   input  logic [LANES-1:0][SEQ_W-1:0]  sch_seq_i,
   input  logic [LANES-1:0]             wb_vld_i,
   input  logic [LANES-1:0][TAG_W-1:0]  wb_tag_i,
   input  logic [LANES-1:0][SEQ_W-1:0]  wb_seq_i,
   output logic                         nxt_rf_o,
   output logic [LANE_W-1:0]            nxt_lane_o,
   output logic [SEQ_W-1:0]             nxt_seq_o,
   output logic                         sch_hit_o,
   output logic                         wb_hit_o
);
   always_comb begin
      nxt_rf_o   = cur_rf_i;
      nxt_lane_o = cur_lane_i;
      nxt_seq_o  = cur_seq_i;
      sch_hit_o  = 1'b0;
      wb_hit_o   = 1'b0;
      // writebacks only retire the producer that currently owns the entry
      for (int i = 0; i < LANES; i++) begin
         if (wb_vld_i[i] && (wb_tag_i[i] == tag_i) && (wb_seq_i[i] == cur_seq_i)) begin
            wb_hit_o = 1'b1;
            nxt_rf_o = 1'b1;
         end
      end
      // schedule writes override; scanning downward leaves the lowest port last
      for (int i = LANES - 1; i >= 0; i--) begin
         if (sch_vld_i[i] && (sch_tag_i[i] == tag_i)) begin
            sch_hit_o  = 1'b1;
            nxt_rf_o   = 1'b0;
            nxt_lane_o = LANE_W'(i);
            nxt_seq_o  = sch_seq_i[i];
         end
      end
   end
endmodule

// File: rtl/bsl_read.sv
module bsl_read #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned TAGS   = 64,
   parameter int unsigned TAG_W  = 6,
   parameter int unsigned SEQ_W  = 4,
   parameter int unsigned LANE_W = 2,
   parameter int unsigned SEL_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [TAG_W-1:0]              tag_i,
   input  logic [TAGS-1:0]               tbl_rf_i,
   input  logic [TAGS-1:0][LANE_W-1:0]   tbl_lane_i,
   input  logic [TAGS-1:0][SEQ_W-1:0]    tbl_seq_i,
   input  logic [LANES-1:0]              sch_vld_i,
   input  logic [LANES-1:0][TAG_W-1:0]   sch_tag_i,
   input  logic [LANES-1:0][SEQ_W-1:0]   sch_seq_i,
   input  logic [LANES-1:0]              wb_vld_i,
   input  logic [LANES-1:0][TAG_W-1:0]   wb_tag_i,
   input  logic [LANES-1:0][SEQ_W-1:0]   wb_seq_i,
   output logic [SEL_W-1:0]              sel_o
);
   logic              fwd_rf;
   logic [LANE_W-1:0] fwd_lane;
   logic [SEQ_W-1:0]  fwd_seq;
   logic              sch_hit;
   logic              wb_hit;

   // same-cycle writes are folded into the stored entry before encoding
   bsl_merge #(
      .LANES(LANES), .TAG_W(TAG_W), .SEQ_W(SEQ_W), .LANE_W(LANE_W)
   ) u_fwd (
      .tag_i      (tag_i),
      .cur_rf_i   (tbl_rf_i[tag_i]),
      .cur_lane_i (tbl_lane_i[tag_i]),
      .cur_seq_i  (tbl_seq_i[tag_i]),
      .sch_vld_i  (sch_vld_i),
      .sch_tag_i  (sch_tag_i),
      .sch_seq_i  (sch_seq_i),
      .wb_vld_i   (wb_vld_i),
      .wb_tag_i   (wb_tag_i),
      .wb_seq_i   (wb_seq_i),
      .nxt_rf_o   (fwd_rf),
      .nxt_lane_o (fwd_lane),
      .nxt_seq_o  (fwd_seq),
      .sch_hit_o  (sch_hit),
      .wb_hit_o   (wb_hit)
   );

   assign sel_o = fwd_rf ? SEL_W'(LANES) : SEL_W'(fwd_lane);

   // R8
   sel_range_chk: assert property (@(posedge clk) disable iff (rst)
      sel_o <= SEL_W'(LANES));
   // R3
   sch_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      sch_hit |-> (sel_o != SEL_W'(LANES)));
   // R4
   wb_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (wb_hit && !sch_hit) |-> (sel_o == SEL_W'(LANES)));
   // R7
   sch0_prio_chk: assert property (@(posedge clk) disable iff (rst)
      (sch_vld_i[0] && (sch_tag_i[0] == tag_i)) |-> (sel_o == '0));
   // fwd_seq feeds only the table path; held here for completeness of the merge
   seq_known_chk: assert property (@(posedge clk) disable iff (rst)
      sch_hit |-> !$isunknown(fwd_seq));
endmodule

// File: rtl/bypass_loc_sb.sv
module bypass_loc_sb #(
   parameter int unsigned LANES = 4,
   parameter int unsigned TAGS  = 64,
   parameter int unsigned SEQ_W = 4,
   parameter int unsigned TAG_W = bsl_pkg::bsl_bits(TAGS),
   parameter int unsigned SEL_W = bsl_pkg::bsl_bits(LANES + 1)
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic [2*LANES-1:0][TAG_W-1:0]     src_tag,
   output logic [2*LANES-1:0][SEL_W-1:0]     src_sel,
   input  logic [LANES-1:0]                  sch_vld,
   input  logic [LANES-1:0][TAG_W-1:0]       sch_tag,
   input  logic [LANES-1:0][SEQ_W-1:0]       sch_seq,
   input  logic [LANES-1:0]                  wb_vld,
   input  logic [LANES-1:0][TAG_W-1:0]       wb_tag,
   input  logic [LANES-1:0][SEQ_W-1:0]       wb_seq
);
   localparam int unsigned LANE_W = bsl_pkg::bsl_bits(LANES);
   localparam int unsigned NSRC   = 2 * LANES;

   // elaboration-time parameter checks
   if (LANES < 1) begin : g_bad_lanes
      $error("bypass_loc_sb: LANES must be at least 1");
   end
   if ((TAGS < 2) || ((1 << TAG_W) != TAGS)) begin : g_bad_tags
      $error("bypass_loc_sb: TAGS must be a power of two, at least 2");
   end
   if (SEQ_W < 1) begin : g_bad_seq
      $error("bypass_loc_sb: SEQ_W must be at least 1");
   end

   logic [TAGS-1:0]             rf_q,   rf_d;
   logic [TAGS-1:0][LANE_W-1:0] lane_q, lane_d;
   logic [TAGS-1:0][SEQ_W-1:0]  seq_q,  seq_d;
   logic [TAGS-1:0]             sch_hit, wb_hit;

   for (genvar t = 0; t < TAGS; t++) begin : g_entry
      bsl_merge #(
         .LANES(LANES), .TAG_W(TAG_W), .SEQ_W(SEQ_W), .LANE_W(LANE_W)
      ) u_upd (
         .tag_i      (TAG_W'(t)),
         .cur_rf_i   (rf_q[t]),
         .cur_lane_i (lane_q[t]),
         .cur_seq_i  (seq_q[t]),
         .sch_vld_i  (sch_vld),
         .sch_tag_i  (sch_tag),
         .sch_seq_i  (sch_seq),
         .wb_vld_i   (wb_vld),
         .wb_tag_i   (wb_tag),
         .wb_seq_i   (wb_seq),
         .nxt_rf_o   (rf_d[t]),
         .nxt_lane_o (lane_d[t]),
         .nxt_seq_o  (seq_d[t]),
         .sch_hit_o  (sch_hit[t]),
         .wb_hit_o   (wb_hit[t])
      );

      // R9
      idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !(sch_hit[t] || wb_hit[t]) |=> $stable({rf_q[t], lane_q[t], seq_q[t]}));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rf_q   <= '1;
         lane_q <= '0;
         seq_q  <= '0;
      end else begin
         rf_q   <= rf_d;
         lane_q <= lane_d;
         seq_q  <= seq_d;
      end
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      bsl_read #(
         .LANES(LANES), .TAGS(TAGS), .TAG_W(TAG_W), .SEQ_W(SEQ_W),
         .LANE_W(LANE_W), .SEL_W(SEL_W)
      ) u_rd (
         .clk        (clk),
         .rst        (rst),
         .tag_i      (src_tag[s]),
         .tbl_rf_i   (rf_q),
         .tbl_lane_i (lane_q),
         .tbl_seq_i  (seq_q),
         .sch_vld_i  (sch_vld),
         .sch_tag_i  (sch_tag),
         .sch_seq_i  (sch_seq),
         .wb_vld_i   (wb_vld),
         .wb_tag_i   (wb_tag),
         .wb_seq_i   (wb_seq),
         .sel_o      (src_sel[s])
      );
   end

   // R1
   reset_rf_chk: assert property (@(posedge clk)
      rst |=> (&rf_q));
endmodule

// File: tb/bypass_loc_sb_bench.sv
module bypass_loc_sb_bench;
   localparam int N     = 4;
   localparam int TAGS  = 64;
   localparam int SEQ_W = 4;
   localparam int TAG_W = 6;
   localparam int SEL_W = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2*N-1:0][TAG_W-1:0] src_tag;
   logic [2*N-1:0][SEL_W-1:0] src_sel;
   logic [N-1:0]              sch_vld;
   logic [N-1:0][TAG_W-1:0]   sch_tag;
   logic [N-1:0][SEQ_W-1:0]   sch_seq;
   logic [N-1:0]              wb_vld;
   logic [N-1:0][TAG_W-1:0]   wb_tag;
   logic [N-1:0][SEQ_W-1:0]   wb_seq;

   bypass_loc_sb #(.LANES(N), .TAGS(TAGS), .SEQ_W(SEQ_W)) u_bypass_loc_sb (
      .clk(clk), .rst(rst), .src_tag(src_tag), .src_sel(src_sel),
      .sch_vld(sch_vld), .sch_tag(sch_tag), .sch_seq(sch_seq),
      .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_seq(wb_seq));

   always #10 clk = ~clk;   // 50 MHz

   int n_chk = 0;
   int n_fail = 0;
   bit m_rf[TAGS];
   int m_lane[TAGS];
   int m_seq[TAGS];

   // reference: where tag t resolves to this cycle, given the driven writes
   task automatic resolve(input int t, output bit r, output int l, output int s);
      bit taken;
      r = m_rf[t]; l = m_lane[t]; s = m_seq[t];
      for (int i = 0; i < N; i++)
         if (wb_vld[i] && int'(wb_tag[i]) == t && int'(wb_seq[i]) == m_seq[t]) r = 1;
      taken = 0;
      for (int i = 0; i < N; i++)
         if (!taken && sch_vld[i] && int'(sch_tag[i]) == t) begin
            taken = 1; r = 0; l = i; s = int'(sch_seq[i]);
         end
   endtask

   task automatic idle();
      sch_vld = '0; sch_tag = '0; sch_seq = '0;
      wb_vld = '0; wb_tag = '0; wb_seq = '0;
      for (int s = 0; s < 2*N; s++) src_tag[s] = TAG_W'(s);
   endtask

   task automatic model_reset();
      for (int t = 0; t < TAGS; t++) begin
         m_rf[t] = 1; m_lane[t] = 0; m_seq[t] = 0;
      end
   endtask

   // called just after a falling edge with inputs set; checks, then clocks
   task automatic step(input string req);
      bit nr[TAGS];
      int nl[TAGS];
      int ns[TAGS];
      bit r; int l; int s;
      #5;
      for (int k = 0; k < 2*N; k++) begin
         int exp_v;
         resolve(int'(src_tag[k]), r, l, s);
         exp_v = r ? N : l;
         n_chk++;
         if (int'(src_sel[k]) !== exp_v) begin
            n_fail++;
            $display("FAIL %s src%0d tag %0d: got %0d expected %0d",
                     req, k, src_tag[k], src_sel[k], exp_v);
         end
      end
      for (int t = 0; t < TAGS; t++) begin
         resolve(t, r, l, s);
         nr[t] = r; nl[t] = l; ns[t] = s;
      end
      @(posedge clk);
      for (int t = 0; t < TAGS; t++) begin
         m_rf[t] = nr[t]; m_lane[t] = nl[t]; m_seq[t] = ns[t];
      end
      @(negedge clk);
   endtask

   task automatic all_src(input int t);
      for (int s = 0; s < 2*N; s++) src_tag[s] = TAG_W'(t);
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      idle();
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: every lookup reports the register-file path after reset
      idle(); step("R1");
      idle(); for (int s = 0; s < 2*N; s++) src_tag[s] = TAG_W'(63 - 5*s); step("R1");

      // R3 then R2: schedule tag 5 on port 2, seq 3
      idle(); sch_vld[2] = 1; sch_tag[2] = 5; sch_seq[2] = 3; all_src(5); step("R3");
      idle(); all_src(5); step("R2");

      // R5: stale writeback (seq 7) ignored now and next cycle
      idle(); wb_vld[1] = 1; wb_tag[1] = 5; wb_seq[1] = 7; all_src(5); step("R5");
      idle(); all_src(5); step("R5");

      // R4: matching writeback visible same cycle and after
      idle(); wb_vld[3] = 1; wb_tag[3] = 5; wb_seq[3] = 3; all_src(5); step("R4");
      idle(); all_src(5); step("R4");

      // R6: schedule beats a matching writeback on the same tag
      idle(); sch_vld[0] = 1; sch_tag[0] = 9; sch_seq[0] = 2; step("R6");
      idle(); sch_vld[1] = 1; sch_tag[1] = 9; sch_seq[1] = 4;
      wb_vld[0] = 1; wb_tag[0] = 9; wb_seq[0] = 2; all_src(9); step("R6");
      idle(); all_src(9); step("R6");

      // R7: ports 3 and 0 collide on tag 12, port 0 wins
      idle(); sch_vld[3] = 1; sch_tag[3] = 12; sch_seq[3] = 1;
      sch_vld[0] = 1; sch_tag[0] = 12; sch_seq[0] = 6; all_src(12); step("R7");
      idle(); all_src(12); step("R7");

      // R8 R9 R10: random mixes over a small tag pool to force collisions
      for (int c = 0; c < 400; c++) begin
         idle();
         for (int i = 0; i < N; i++) begin
            sch_vld[i] = ($urandom % 3) == 0;
            sch_tag[i] = TAG_W'($urandom % 8);
            sch_seq[i] = SEQ_W'($urandom);
            wb_vld[i]  = ($urandom % 3) == 0;
            wb_tag[i]  = TAG_W'($urandom % 8);
            wb_seq[i]  = (($urandom % 4) != 0) ? SEQ_W'(m_seq[int'(wb_tag[i])])
                                                : SEQ_W'($urandom);
         end
         for (int s = 0; s < 2*N; s++) src_tag[s] = TAG_W'($urandom % 10);
         step("R8 R9 R10");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule